// File: doc/BRIEF.md
# Blade Power Sequencing Controller

This block runs the digital side of powering a hot-pluggable server blade up and down. The standby rail and this logic are alive as soon as the blade is seated. The main 5 V gate FET and the secondary converters stay dark until the management side sends a power-on command. The rails are then switched on one at a time, in an order fixed by a parameter table, with a programmable gap between steps. After the last step the block waits for the active-low power-good input. If power-good does not arrive within a programmable number of cycles, the block raises a fault and drops every rail. A power-off command releases the rails in the reverse order.

The connector's last-mate signal is active low. When it goes away, every main enable is forced off at once through combinational gating, without waiting for a clock edge. A reset of the management processor blocks new commands but does not touch the enable state, so a watchdog reset or a firmware reload never drops or raises a rail. While the rails are up, a margining request drives every rail's active-low up or down control together. Power-good supervision is suspended for as long as the request stays active. The active-low green LED is lit only while the blade is fully on and power-good is asserted.

Top module: `blade_pwr_seq`

## Requirements
- R1: While `rst_n` is low at a clock edge, the following edge leaves every rail enable at 0, every margin control at 1, the LED off (1) and `pwr_fault` at 0.
- R2: A power-on command is accepted at edge E0. It is a `cmd_stb` pulse with `cmd_on`=1, sent while the blade is mated, `mgmt_rst_n` is 1 and the block is off. After acceptance, the rail at table entry k turns on at edge E0 + k*(`step_dly`+1). The rail vector is {`conv_en`, `fet_en`}, with bit 0 as the FET. Entry k is `SEQ_ORDER[2k+1:2k]`, and the default order is 0, 2, 1, 3.
- R3: While `mgmt_rst_n` is 0, commands are ignored. The rail enables keep their value when idle or fully on, and an ongoing ramp keeps going.
- R4: Once all rails are on, the block reaches the on state at the first edge that samples `pg_n`=0. The LED (`led_act_n`=0) is lit only in the on state while `pg_n`=0 and the blade is mated.
- R5: Waiting for power-good starts at edge W0 = E0 + N*(`step_dly`+1). If `pg_n` stays 1, edge W0+1+`pg_tmo` turns every rail off and sets `pwr_fault`. The fault flag clears at the next accepted power-on.
- R6: A power-off command (`cmd_stb`, `cmd_on`=0, accepted at edge D0) turns off table entry N-1-j at edge D0 + j*(`step_dly`+1).
- R7: While `mated_n` is 1, all rail enables read 0 in the same cycle, and the block returns to off. Re-mating does not re-enable any rail.
- R8: In the on state, `margin_sel` 01 drives every `mrg_up_n` low and 10 drives every `mrg_dn_n` low. Codes 00 and 11 leave both vectors high. In every other state both vectors stay high, and an up and down pair is never low together.
- R9: In the on state, `pg_n`=1 with no margining turns all rails off at the next edge and sets `pwr_fault`. While margining is requested, `pg_n`=1 is ignored.
- R10: Commands are ignored while `mated_n` is 1. A power-on command is ignored when the block is not off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock from the standby domain |
| rst_n | input | 1 | Synchronous active-low reset from the standby power-on reset |
| mated_n | input | 1 | Last-mate connector pin, low when fully seated |
| mgmt_rst_n | input | 1 | Management processor reset, active low |
| cmd_stb | input | 1 | One-cycle command strobe |
| cmd_on | input | 1 | Command code: 1 power-on, 0 power-off |
| pg_n | input | 1 | Combined power-good, active low |
| margin_sel | input | 2 | Margin request: 01 high, 10 low, 00 or 11 none |
| step_dly | input | DLY_W | Cycles between sequence steps, minus one |
| pg_tmo | input | TMO_W | Power-good timeout in cycles |
| fet_en | output | 1 | Main 5 V gate FET enable |
| conv_en | output | NUM_RAILS-1 | Secondary converter enables |
| mrg_up_n | output | NUM_RAILS | Per-rail margin-up controls, active low |
| mrg_dn_n | output | NUM_RAILS | Per-rail margin-down controls, active low |
| led_act_n | output | 1 | Green active LED drive, active low |
| pwr_fault | output | 1 | Power-good fault flag |

## Verification
The properties assume that `mated_n`, `pg_n` and `margin_sel` are synchronous to the clock and change only between edges. They also assume that `step_dly` and `pg_tmo` hold steady during a sequence. The stimulus drives all of these on the falling edge and reloads the two timing inputs only while the block is off. `cmd_stb` is kept to one-cycle pulses. The random stimulus draws step gaps, timeouts, power-good arrival times and management-reset states only from the ranges that the expected-value functions model.

// File: rtl/bps_pkg.sv
// Package: shared types of the blade power sequencer.
package bps_pkg;
    typedef enum logic [2:0] {
        ST_OFF     = 3'd0,
        ST_RAMP    = 3'd1,
        ST_WAIT_PG = 3'd2,
        ST_ON      = 3'd3,
        ST_DOWN    = 3'd4
    } seq_state_t;

    typedef enum logic [1:0] {
        MRG_NONE = 2'b00,
        MRG_HIGH = 2'b01,
        MRG_LOW  = 2'b10,
        MRG_RSVD = 2'b11
    } mrg_sel_t;
endpackage

// File: rtl/bps_step_timer.sv
// Step timer: counts cycles since the last clear and flags when the count
// equals the chosen limit. Assumes the controller clears it on every step.
module bps_step_timer #(
    parameter int DLY_W = 8,
    parameter int TMO_W = 12,
    localparam int TW = (DLY_W > TMO_W) ? DLY_W : TMO_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             use_tmo,
    input  logic [DLY_W-1:0] step_dly,
    input  logic [TMO_W-1:0] pg_tmo,
    output logic             hit
);
    logic [TW-1:0] cnt_q;
    logic [TW-1:0] limit;

    // Pick the limit that applies to the current phase.
    always_comb limit = use_tmo ? TW'(pg_tmo) : TW'(step_dly);

    always_comb hit = (cnt_q == limit);

    // Count up, saturating at the limit, until cleared.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            cnt_q <= '0;
        else if (!hit)
            cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/bps_seq_fsm.sv
// Sequencer FSM: walks the rail table up and down, waits for power-good,
// supervises power-good while on, and drops everything on a fault or unmating.
// Assumes go_on/go_off are already qualified by mating and management reset.
module bps_seq_fsm
    import bps_pkg::*;
#(
    parameter int          NUM_RAILS = 4,
    parameter logic [31:0] SEQ_ORDER = 32'h0000_00D8,
    localparam int         STW = (NUM_RAILS > 1) ? $clog2(NUM_RAILS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 mated,
    input  logic                 go_on,
    input  logic                 go_off,
    input  logic                 pg_ok,
    input  logic                 pg_masked,
    input  logic                 hit,
    output seq_state_t           state,
    output logic [NUM_RAILS-1:0] rail_q,
    output logic                 fault,
    output logic                 tmr_clr,
    output logic                 use_tmo
);
    localparam logic [STW-1:0] LAST = STW'(NUM_RAILS - 1);

    logic [STW-1:0] step_q;

    // Table lookup: rail index held in entry k.
    function automatic logic [STW-1:0] seq_at(input logic [STW-1:0] k);
        return SEQ_ORDER[int'(k)*STW +: STW];
    endfunction

    // Timer clear: any phase without a running wait, or any step or exit.
    always_comb begin
        unique case (state)
            ST_RAMP, ST_WAIT_PG: tmr_clr = hit || go_off || !mated;
            ST_DOWN:             tmr_clr = hit || !mated;
            default:             tmr_clr = 1'b1;
        endcase
    end

    always_comb use_tmo = (state == ST_WAIT_PG);

    // Main sequencing state, rail enables and fault flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_OFF;
            rail_q <= '0;
            step_q <= '0;
            fault  <= 1'b0;
        end else if (!mated) begin
            state  <= ST_OFF;
            rail_q <= '0;
            step_q <= '0;
        end else begin
            unique case (state)
                ST_OFF: if (go_on) begin
                    state          <= ST_RAMP;
                    step_q         <= '0;
                    rail_q         <= '0;
                    rail_q[seq_at('0)] <= 1'b1;
                    fault          <= 1'b0;
                end
                ST_RAMP: begin
                    if (go_off) begin
                        state <= ST_DOWN;
                        rail_q[seq_at(step_q)] <= 1'b0;
                    end else if (hit) begin
                        if (step_q == LAST) begin
                            state <= ST_WAIT_PG;
                        end else begin
                            step_q <= step_q + 1'b1;
                            rail_q[seq_at(step_q + 1'b1)] <= 1'b1;
                        end
                    end
                end
                ST_WAIT_PG: begin
                    if (go_off) begin
                        state <= ST_DOWN;
                        rail_q[seq_at(step_q)] <= 1'b0;
                    end else if (pg_ok) begin
                        state <= ST_ON;
                    end else if (hit) begin
                        state  <= ST_OFF;
                        rail_q <= '0;
                        step_q <= '0;
                        fault  <= 1'b1;
                    end
                end
                ST_ON: begin
                    if (go_off) begin
                        state <= ST_DOWN;
                        rail_q[seq_at(step_q)] <= 1'b0;
                    end else if (!pg_ok && !pg_masked) begin
                        state  <= ST_OFF;
                        rail_q <= '0;
                        step_q <= '0;
                        fault  <= 1'b1;
                    end
                end
                ST_DOWN: if (hit) begin
                    if (step_q == '0) begin
                        state <= ST_OFF;
                    end else begin
                        step_q <= step_q - 1'b1;
                        rail_q[seq_at(step_q - 1'b1)] <= 1'b0;
                    end
                end
                default: begin
                    state  <= ST_OFF;
                    rail_q <= '0;
                end
            endcase
        end
    end
endmodule

// File: rtl/bps_margin_ctl.sv
// Margin control: turns the request into per-rail active-low up/down drives
// while the blade is on, and tells the FSM to mask power-good.
module bps_margin_ctl
    import bps_pkg::*;
#(
    parameter int NUM_RAILS = 4
) (
    input  logic                 powered,
    input  logic [1:0]           margin_sel,
    output logic [NUM_RAILS-1:0] mrg_up_n,
    output logic [NUM_RAILS-1:0] mrg_dn_n,
    output logic                 masked
);
    logic go_high;
    logic go_low;

    // Decode the request, valid only in the on state.
    always_comb begin
        go_high = powered && (mrg_sel_t'(margin_sel) == MRG_HIGH);
        go_low  = powered && (mrg_sel_t'(margin_sel) == MRG_LOW);
        masked  = go_high || go_low;
    end

    for (genvar i = 0; i < NUM_RAILS; i++) begin : g_rail_mrg
        // Per-rail drive; all rails move together.
        always_comb begin
            mrg_up_n[i] = !go_high;
            mrg_dn_n[i] = !go_low;
        end
    end
endmodule

// File: rtl/bps_rail_gate.sv
// Rail gate: forces each registered enable low the moment mating is lost,
// without waiting for a clock edge.
module bps_rail_gate #(
    parameter int NUM_RAILS = 4
) (
    input  logic                 mated,
    input  logic [NUM_RAILS-1:0] rail_q,
    output logic [NUM_RAILS-1:0] rail_out
);
    for (genvar i = 0; i < NUM_RAILS; i++) begin : g_gate
        // Combinational kill of one enable.
        always_comb rail_out[i] = rail_q[i] && mated;
    end
endmodule

// File: rtl/blade_pwr_seq.sv
// Top of the blade power sequencer. Qualifies commands, connects the FSM,
// step timer, margin decode and asynchronous rail gating. Assumes all inputs
// are synchronous to clk except mated_n, whose effect on enables is immediate.
module blade_pwr_seq
    import bps_pkg::*;
#(
    parameter int          NUM_RAILS = 4,
    parameter int          DLY_W     = 8,
    parameter int          TMO_W     = 12,
    parameter logic [31:0] SEQ_ORDER = 32'h0000_00D8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 mated_n,
    input  logic                 mgmt_rst_n,
    input  logic                 cmd_stb,
    input  logic                 cmd_on,
    input  logic                 pg_n,
    input  logic [1:0]           margin_sel,
    input  logic [DLY_W-1:0]     step_dly,
    input  logic [TMO_W-1:0]     pg_tmo,
    output logic                 fet_en,
    output logic [NUM_RAILS-2:0] conv_en,
    output logic [NUM_RAILS-1:0] mrg_up_n,
    output logic [NUM_RAILS-1:0] mrg_dn_n,
    output logic                 led_act_n,
    output logic                 pwr_fault
);
    logic                 mated;
    logic                 cmd_ok;
    logic                 go_on;
    logic                 go_off;
    logic                 hit;
    logic                 tmr_clr;
    logic                 use_tmo;
    logic                 masked;
    logic                 powered;
    seq_state_t           state;
    logic [NUM_RAILS-1:0] rail_q;
    logic [NUM_RAILS-1:0] rail_out;

    // Command qualification: only when seated and management is out of reset.
    always_comb begin
        mated   = !mated_n;
        cmd_ok  = cmd_stb && mated && mgmt_rst_n;
        go_on   = cmd_ok && cmd_on;
        go_off  = cmd_ok && !cmd_on;
        powered = (state == ST_ON) && mated;
    end

    bps_step_timer #(.DLY_W(DLY_W), .TMO_W(TMO_W)) u_tmr (
        .clk(clk), .rst_n(rst_n), .clr(tmr_clr), .use_tmo(use_tmo),
        .step_dly(step_dly), .pg_tmo(pg_tmo), .hit(hit)
    );

    bps_seq_fsm #(.NUM_RAILS(NUM_RAILS), .SEQ_ORDER(SEQ_ORDER)) u_fsm (
        .clk(clk), .rst_n(rst_n), .mated(mated), .go_on(go_on),
        .go_off(go_off), .pg_ok(!pg_n), .pg_masked(masked), .hit(hit),
        .state(state), .rail_q(rail_q), .fault(pwr_fault),
        .tmr_clr(tmr_clr), .use_tmo(use_tmo)
    );

    bps_margin_ctl #(.NUM_RAILS(NUM_RAILS)) u_mrg (
        .powered(powered), .margin_sel(margin_sel),
        .mrg_up_n(mrg_up_n), .mrg_dn_n(mrg_dn_n), .masked(masked)
    );

    bps_rail_gate #(.NUM_RAILS(NUM_RAILS)) u_gate (
        .mated(mated), .rail_q(rail_q), .rail_out(rail_out)
    );

    // Output split and LED drive.
    always_comb begin
        fet_en    = rail_out[0];
        conv_en   = rail_out[NUM_RAILS-1:1];
        led_act_n = !(powered && !pg_n);
    end
endmodule

// File: rtl/bps_chk.sv
// Checker for the blade power sequencer, attached by bind. Observes ports only.
module bps_chk #(
    parameter int NUM_RAILS = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 mated_n,
    input logic                 mgmt_rst_n,
    input logic                 pg_n,
    input logic                 fet_en,
    input logic [NUM_RAILS-2:0] conv_en,
    input logic [NUM_RAILS-1:0] mrg_up_n,
    input logic [NUM_RAILS-1:0] mrg_dn_n,
    input logic                 led_act_n,
    input logic                 pwr_fault
);
    logic [NUM_RAILS-1:0] en;
    always_comb en = {conv_en, fet_en};

    assert_unmated_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mated_n |-> (en == '0));

    assert_margin_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((~mrg_up_n) & (~mrg_dn_n)) == '0);

    assert_margin_needs_power_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (en == '0) |-> ((&mrg_up_n) && (&mrg_dn_n)));

    assert_led_needs_pg_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !led_act_n |-> (!pg_n && (&en)));

    assert_mgmt_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!mgmt_rst_n && !mated_n && en == '0) |=> (en == '0));

    assert_fault_drops_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwr_fault) |-> (en == '0));
endmodule

bind blade_pwr_seq bps_chk #(.NUM_RAILS(NUM_RAILS)) u_chk (
    .clk(clk), .rst_n(rst_n), .mated_n(mated_n), .mgmt_rst_n(mgmt_rst_n),
    .pg_n(pg_n), .fet_en(fet_en), .conv_en(conv_en), .mrg_up_n(mrg_up_n),
    .mrg_dn_n(mrg_dn_n), .led_act_n(led_act_n), .pwr_fault(pwr_fault)
);

// File: tb/sim_blade_pwr_seq.sv
module sim_blade_pwr_seq;
    localparam int          N     = 4;
    localparam logic [31:0] ORDER = 32'h0000_00D8;

    logic clk = 1'b0;
    logic rst_n = 1'b0, mated_n = 1'b0, mgmt_rst_n = 1'b1;
    logic cmd_stb = 1'b0, cmd_on = 1'b0, pg_n = 1'b1;
    logic [1:0]  margin_sel = 2'b00;
    logic [7:0]  step_dly = 8'd0;
    logic [11:0] pg_tmo = 12'd4;
    logic        fet_en, led_act_n, pwr_fault;
    logic [N-2:0] conv_en;
    logic [N-1:0] mrg_up_n, mrg_dn_n;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    blade_pwr_seq u0 (
        .clk(clk), .rst_n(rst_n), .mated_n(mated_n), .mgmt_rst_n(mgmt_rst_n),
        .cmd_stb(cmd_stb), .cmd_on(cmd_on), .pg_n(pg_n), .margin_sel(margin_sel),
        .step_dly(step_dly), .pg_tmo(pg_tmo), .fet_en(fet_en), .conv_en(conv_en),
        .mrg_up_n(mrg_up_n), .mrg_dn_n(mrg_dn_n), .led_act_n(led_act_n),
        .pwr_fault(pwr_fault)
    );

    function automatic int seq_at(int k);
        return int'(ORDER[k*2 +: 2]);
    endfunction

    // Expected enables once table entries 0..k are on (k<0: none).
    function automatic logic [N-1:0] mask_upto(int k);
        logic [N-1:0] m = '0;
        for (int j = 0; j <= k; j++) m[seq_at(j)] = 1'b1;
        return m;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic chk_en(string req, logic [N-1:0] exp);
        check(req, 32'({conv_en, fet_en}), 32'(exp));
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(logic on);
        cmd_stb = 1'b1; cmd_on = on;
        tick(1);
        cmd_stb = 1'b0;
    endtask

    // Power up; pass=1 asserts power-good p cycles into the wait.
    task automatic power_up(int d, int tmo, bit pass, int p, bit mgmt_glitch);
        step_dly = 8'(d); pg_tmo = 12'(tmo); pg_n = 1'b1;
        pulse(1'b1);
        if (mgmt_glitch) mgmt_rst_n = 1'b0;   // R3: ramp continues in mgmt reset
        chk_en("R2 first step", mask_upto(0));
        for (int k = 1; k < N; k++) begin
            tick(d + 1);
            chk_en("R2 step order", mask_upto(k));
        end
        tick(d + 1);
        mgmt_rst_n = 1'b1;
        if (pass) begin
            tick(p);
            pg_n = 1'b0;
            tick(1);
            check("R4 led on", 32'(led_act_n), 32'd0);
            chk_en("R4 all on", mask_upto(N - 1));
            check("R5 no fault", 32'(pwr_fault), 32'd0);
        end else begin
            tick(tmo);
            chk_en("R5 before timeout", mask_upto(N - 1));
            check("R4 led dark in wait", 32'(led_act_n), 32'd1);
            tick(1);
            chk_en("R5 timeout off", '0);
            check("R5 fault set", 32'(pwr_fault), 32'd1);
        end
    endtask

    task automatic power_down(int d);
        pulse(1'b0);
        check("R4 led off in down", 32'(led_act_n), 32'd1);
        chk_en("R6 first release", mask_upto(N - 2));
        for (int j = 1; j < N; j++) begin
            tick(d + 1);
            chk_en("R6 reverse order", mask_upto(N - 2 - j));
        end
        tick(d + 2);
        pg_n = 1'b1;
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            summary();
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        tick(3);
        // R1: reset state
        check("R1 enables", 32'({conv_en, fet_en}), 32'd0);
        check("R1 margin up", 32'(mrg_up_n), 32'hF);
        check("R1 margin dn", 32'(mrg_dn_n), 32'hF);
        check("R1 led", 32'(led_act_n), 32'd1);
        check("R1 fault", 32'(pwr_fault), 32'd0);
        rst_n = 1'b1;
        tick(2);

        // R3: command blocked in mgmt reset while off
        mgmt_rst_n = 1'b0; pulse(1'b1); tick(3);
        chk_en("R3 on ignored in mgmt reset", '0);
        mgmt_rst_n = 1'b1;

        // R10: command ignored while unmated
        mated_n = 1'b1; pulse(1'b1); tick(2); mated_n = 1'b0; tick(2);
        chk_en("R10 unmated command ignored", '0);

        // Directed bring-up
        power_up(2, 5, 1, 0, 0);
        pulse(1'b1); tick(3);
        chk_en("R10 second on ignored", mask_upto(N - 1));
        // R3: off blocked in mgmt reset, enables held
        mgmt_rst_n = 1'b0; pulse(1'b0); tick(5);
        chk_en("R3 enables held", mask_upto(N - 1));
        mgmt_rst_n = 1'b1;
        // R8 margining decode
        margin_sel = 2'b01; #1;
        check("R8 high up", 32'(mrg_up_n), 32'h0);
        check("R8 high dn", 32'(mrg_dn_n), 32'hF);
        margin_sel = 2'b10; #1;
        check("R8 low up", 32'(mrg_up_n), 32'hF);
        check("R8 low dn", 32'(mrg_dn_n), 32'h0);
        margin_sel = 2'b11; #1;
        check("R8 rsvd up", 32'(mrg_up_n), 32'hF);
        check("R8 rsvd dn", 32'(mrg_dn_n), 32'hF);
        // R9: pg ignored while margining
        margin_sel = 2'b01; pg_n = 1'b1; tick(4);
        chk_en("R9 masked pg", mask_upto(N - 1));
        check("R9 no fault masked", 32'(pwr_fault), 32'd0);
        pg_n = 1'b0; margin_sel = 2'b00; tick(1);
        pg_n = 1'b1; tick(1);
        chk_en("R9 pg loss off", '0);
        check("R9 pg loss fault", 32'(pwr_fault), 32'd1);
        check("R8 margin idle off", 32'(mrg_up_n), 32'hF);
        tick(2);

        // R5 directed timeout, then normal cycle clears fault
        power_up(0, 3, 0, 0, 0);
        power_up(1, 6, 1, 6, 1);
        power_down(1);

        // R7: unmating kills enables at once
        power_up(0, 4, 1, 2, 0);
        mated_n = 1'b1; #1;
        chk_en("R7 immediate drop", '0);
        tick(2); mated_n = 1'b0; tick(3);
        chk_en("R7 stays off after remate", '0);
        check("R7 led off", 32'(led_act_n), 32'd1);
        pg_n = 1'b1;

        // Random cycles
        for (int it = 0; it < 24; it++) begin
            int d, tmo, p;
            bit pass, g;
            d = int'($urandom % 5);
            tmo = 2 + int'($urandom % 8);
            pass = ($urandom % 4) != 0;
            p = int'($urandom % (tmo + 1));
            g = $urandom % 2;
            power_up(d, tmo, pass, p, g);
            if (pass) power_down(d);
            else tick(2);
        end

        done = 1;
        summary();
    end
endmodule